// File: doc/BRIEF.md
# Write-Back Write-Allocate L1 Data Cache Tag Controller

This block is the tag and metadata side of a set-associative level-one data cache. The cache holds 2^C bytes in 2^B-byte lines, with 2^S ways per set. The block holds a tag, a valid bit and a dirty bit for every line. Line data, the backing memory and the policy that picks a replacement way all live outside it. The way chosen for replacement arrives on an input port. The block sends touch strobes out so that the external policy can update its state.

A client issues one byte-addressed load or store at a time over a valid/ready handshake. The block checks its tag store first. On a miss it queries a small external buffer of recently evicted lines in the same cycle; that query adds no latency. A line found in that buffer is moved back into the cache and keeps its dirty state. A line found in neither place is requested from memory and installed when memory signals that the fill is complete. Memory takes 60 cycles in the intended system, but the block waits for the done pulse whatever the delay. Any valid line that an install displaces is reported to the buffer together with its dirty bit. Saturating counters track accesses, misses and evictions for performance analysis.

Top module: `l1d_tag_ctrl`

## Requirements
- R1: After reset every line is invalid and clean, all counters read zero, `reqReady` is 1, and the first access to any address misses.
- R2: The address splits into tag `addr[63:C-S]`, set index `addr[C-S-1:B]` and byte offset `addr[B-1:0]`. Two addresses that differ only in the offset hit the same line.
- R3: A request is accepted on the clock edge where `reqValid` and `reqReady` are both 1. The next cycle is the lookup cycle. A hit or a miss served by the victim buffer raises `rspValid` for one cycle in the cycle after lookup, with `rspHit` set for a cache hit.
- R4: On a cache miss, `vcQuery` is 1 during the lookup cycle and `vcQueryAddr` carries the line address `addr[63:B]`. When `vcHit` is 1, the line is installed in that same cycle, `rspFromVictim` is set and no memory request is made. On a cache hit, no query is made.
- R5: A line installed from the victim buffer is dirty if `vcDirty` was 1 or the access is a store.
- R6: On a miss in both the cache and the victim buffer, `memReqValid` stays 1 with a steady `memReqAddr` = `addr[63:B]` until the cycle in which `memFillDone` is 1. The line is installed in that cycle and the response follows in the next cycle. A line filled by a load is clean.
- R7: A store marks its line dirty, both when it hits and when it allocates on a miss.
- R8: The install way is the lowest-numbered invalid way of the set. When every way of the set is valid, the install way is `replWay`.
- R9: An install over a valid line raises `evictValid` in the install cycle. `evictAddr` then carries the displaced line's `{tag, index}` and `evictDirty` carries its dirty bit.
- R10: `replTouch` pulses for one cycle on every hit and every install, with `replSet` and `replTouchWay` naming the line and `replIsInstall` = 1 for installs and 0 for hits.
- R11: Eight counters saturate at 2^CNT_W-1: accesses, loads, stores, misses, load misses, store misses, evictions and dirty evictions.
- R12: `reqReady` is 0 from the cycle after acceptance until the response cycle has ended, so that only one access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller idle and able to accept a request |
| reqAddr | input | ADDR_W | Byte address |
| reqStore | input | 1 | 1 = store, 0 = load |
| rspValid | output | 1 | Response cycle of the current access |
| rspHit | output | 1 | The access hit in the cache |
| rspFromVictim | output | 1 | The miss was served from the victim buffer |
| vcQuery | output | 1 | Victim buffer lookup strobe |
| vcQueryAddr | output | ADDR_W-B | Line address being looked up |
| vcHit | input | 1 | Victim buffer holds the queried line (same cycle) |
| vcDirty | input | 1 | Dirty state of that line in the victim buffer |
| memReqValid | output | 1 | Fill request to memory, held until done |
| memReqAddr | output | ADDR_W-B | Line address to fetch |
| memFillDone | input | 1 | Memory fill complete |
| replWay | input | S | Way chosen by the external replacement policy |
| replTouch | output | 1 | Replacement-state update strobe |
| replIsInstall | output | 1 | The touch is an install, not a hit |
| replSet | output | C-S-B | Set index of the touched line |
| replTouchWay | output | S | Way of the touched line |
| evictValid | output | 1 | A valid line is being displaced |
| evictAddr | output | ADDR_W-B | Displaced line's {tag, index} |
| evictDirty | output | 1 | Displaced line was dirty |
| cntAccess | output | CNT_W | Accesses |
| cntLoad | output | CNT_W | Load accesses |
| cntStore | output | CNT_W | Store accesses |
| cntMiss | output | CNT_W | Cache misses |
| cntMissLoad | output | CNT_W | Load misses |
| cntMissStore | output | CNT_W | Store misses |
| cntEvict | output | CNT_W | Lines evicted |
| cntDirtyEvict | output | CNT_W | Dirty lines evicted |

## Verification
The touch, query and eviction strobes are combinational outputs. For hits and for misses served by the victim buffer, they are due in the lookup cycle, one cycle after acceptance. For memory fills, they are due in the same cycle that `memFillDone` is driven, so the bench drives `memFillDone` at a falling edge and samples a moment later. The response comes one cycle after the install or hit decision, and the counters show the new values from that response cycle on; the bench reads them once the controller is back in idle. Every sample is taken at a falling edge, counted from the accepting rising edge. A reference model of the tag store and victim buffer supplies the expected values.

// File: rtl/l1d_tag_pkg.sv
package l1d_tag_pkg;

  // Strobes from the control FSM to the tag datapath.
  typedef struct packed {
    logic capture;        // latch a new request
    logic commitHit;      // hit resolved this cycle
    logic commitInstall;  // install into the chosen way this cycle
    logic fromVictim;     // install source is the victim buffer
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_RESP
  } state_t;

  localparam int NUM_CNT = 8;

endpackage

// File: rtl/l1d_tag_dp.sv
module l1d_tag_dp
  import l1d_tag_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int C      = 10,
  parameter int B      = 6,
  parameter int S      = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [ADDR_W-B-1:0]  reqBlk,
  input  logic                 reqStore,
  input  logic                 vcDirty,
  input  logic [S-1:0]         replWay,
  output logic                 l1Hit,
  output logic                 storeQ,
  output logic [ADDR_W-B-1:0]  blkAddr,
  output logic [C-S-B-1:0]     setIdx,
  output logic [S-1:0]         hitWay,
  output logic [S-1:0]         fillWay,
  output logic                 victimValid,
  output logic                 victimDirty,
  output logic [ADDR_W-B-1:0]  victimAddr
);

  localparam int WAYS  = 1 << S;
  localparam int IDX_W = C - S - B;
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - (C - S);
  localparam int BLK_W = ADDR_W - B;

  logic [BLK_W-1:0] blkQ;
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [WAYS-1:0]  validQ [SETS];
  logic [WAYS-1:0]  dirtyQ [SETS];

  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  hitVec;
  logic [WAYS-1:0]  setValid;

  assign blkAddr  = blkQ;
  assign setIdx   = blkQ[IDX_W-1:0];
  assign reqTag   = blkQ[BLK_W-1:IDX_W];
  assign setValid = validQ[setIdx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = setValid[w] && (tagQ[setIdx][w] == reqTag);
  end

  assign l1Hit = |hitVec;

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = S'(w);
    end
  end

  // Lowest invalid way first, otherwise the external policy's choice.
  always_comb begin
    fillWay = replWay;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!setValid[w]) fillWay = S'(w);
    end
  end

  assign victimValid = setValid[fillWay];
  assign victimDirty = dirtyQ[setIdx][fillWay];
  assign victimAddr  = {tagQ[setIdx][fillWay], setIdx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkQ   <= '0;
      storeQ <= 1'b0;
    end else if (stb.capture) begin
      blkQ   <= reqBlk;
      storeQ <= reqStore;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
      end
    end else begin
      if (stb.commitHit && storeQ) dirtyQ[setIdx][hitWay] <= 1'b1;
      if (stb.commitInstall) begin
        validQ[setIdx][fillWay] <= 1'b1;
        dirtyQ[setIdx][fillWay] <= storeQ | (stb.fromVictim & vcDirty);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.commitInstall) tagQ[setIdx][fillWay] <= reqTag;
  end

endmodule

// File: rtl/l1d_tag_fsm.sv
module l1d_tag_fsm
  import l1d_tag_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    l1Hit,
  input  logic    vcHit,
  input  logic    memFillDone,
  output strobe_t stb,
  output logic    reqReady,
  output logic    vcQuery,
  output logic    memReqValid,
  output logic    rspValid,
  output logic    rspHit,
  output logic    rspFromVictim
);

  state_t state, stateNext;
  logic   hitQ, vicQ;

  always_comb begin
    stb         = '0;
    stateNext   = state;
    vcQuery     = 1'b0;
    memReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        stb.capture = reqValid;
        if (reqValid) stateNext = ST_LOOK;
      end
      ST_LOOK: begin
        if (l1Hit) begin
          stb.commitHit = 1'b1;
          stateNext     = ST_RESP;
        end else begin
          vcQuery = 1'b1;
          if (vcHit) begin
            stb.commitInstall = 1'b1;
            stb.fromVictim    = 1'b1;
            stateNext         = ST_RESP;
          end else begin
            stateNext = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memReqValid = 1'b1;
        if (memFillDone) begin
          stb.commitInstall = 1'b1;
          stateNext         = ST_RESP;
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      hitQ  <= 1'b0;
      vicQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_LOOK) begin
        hitQ <= l1Hit;
        vicQ <= !l1Hit && vcHit;
      end
    end
  end

  assign reqReady      = (state == ST_IDLE);
  assign rspValid      = (state == ST_RESP);
  assign rspHit        = hitQ;
  assign rspFromVictim = vicQ;

endmodule

// File: rtl/l1d_tag_stats.sv
module l1d_tag_stats
  import l1d_tag_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_CNT-1:0]              evt,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN)                         cnt[i] <= '0;
      else if (evt[i] && cnt[i] != CNT_MAX) cnt[i] <= cnt[i] + 1'b1;
    end
  end

endmodule

// File: rtl/l1d_tag_ctrl.sv
module l1d_tag_ctrl
  import l1d_tag_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int C      = 10,
  parameter int B      = 6,
  parameter int S      = 1,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqStore,
  output logic                rspValid,
  output logic                rspHit,
  output logic                rspFromVictim,
  output logic                vcQuery,
  output logic [ADDR_W-B-1:0] vcQueryAddr,
  input  logic                vcHit,
  input  logic                vcDirty,
  output logic                memReqValid,
  output logic [ADDR_W-B-1:0] memReqAddr,
  input  logic                memFillDone,
  input  logic [S-1:0]        replWay,
  output logic                replTouch,
  output logic                replIsInstall,
  output logic [C-S-B-1:0]    replSet,
  output logic [S-1:0]        replTouchWay,
  output logic                evictValid,
  output logic [ADDR_W-B-1:0] evictAddr,
  output logic                evictDirty,
  output logic [CNT_W-1:0]    cntAccess,
  output logic [CNT_W-1:0]    cntLoad,
  output logic [CNT_W-1:0]    cntStore,
  output logic [CNT_W-1:0]    cntMiss,
  output logic [CNT_W-1:0]    cntMissLoad,
  output logic [CNT_W-1:0]    cntMissStore,
  output logic [CNT_W-1:0]    cntEvict,
  output logic [CNT_W-1:0]    cntDirtyEvict
);

  localparam int BLK_W = ADDR_W - B;

  strobe_t          stb;
  logic             l1Hit, storeQ, victimValid, victimDirty;
  logic [BLK_W-1:0] blkAddr, victimAddr;
  logic [C-S-B-1:0] setIdx;
  logic [S-1:0]     hitWay, fillWay;
  logic             accessEvt;
  logic [NUM_CNT-1:0]            evt;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  l1d_tag_fsm i_fsm (
    .clk, .rstN, .reqValid, .l1Hit, .vcHit, .memFillDone,
    .stb, .reqReady, .vcQuery, .memReqValid, .rspValid, .rspHit, .rspFromVictim
  );

  l1d_tag_dp #(.ADDR_W(ADDR_W), .C(C), .B(B), .S(S)) i_dp (
    .clk, .rstN, .stb,
    .reqBlk(reqAddr[ADDR_W-1:B]), .reqStore, .vcDirty, .replWay,
    .l1Hit, .storeQ, .blkAddr, .setIdx, .hitWay, .fillWay,
    .victimValid, .victimDirty, .victimAddr
  );

  assign vcQueryAddr   = blkAddr;
  assign memReqAddr    = blkAddr;
  assign replTouch     = stb.commitHit | stb.commitInstall;
  assign replIsInstall = stb.commitInstall;
  assign replSet       = setIdx;
  assign replTouchWay  = stb.commitInstall ? fillWay : hitWay;
  assign evictValid    = stb.commitInstall & victimValid;
  assign evictAddr     = victimAddr;
  assign evictDirty    = victimDirty;

  assign accessEvt = stb.commitHit | stb.commitInstall;
  assign evt = {evictValid & victimDirty,
                evictValid,
                stb.commitInstall & storeQ,
                stb.commitInstall & !storeQ,
                stb.commitInstall,
                accessEvt & storeQ,
                accessEvt & !storeQ,
                accessEvt};

  l1d_tag_stats #(.CNT_W(CNT_W)) i_stats (.clk, .rstN, .evt, .cnt);

  assign cntAccess     = cnt[0];
  assign cntLoad       = cnt[1];
  assign cntStore      = cnt[2];
  assign cntMiss       = cnt[3];
  assign cntMissLoad   = cnt[4];
  assign cntMissStore  = cnt[5];
  assign cntEvict      = cnt[6];
  assign cntDirtyEvict = cnt[7];

endmodule

// File: rtl/l1d_tag_chk.sv
module l1d_tag_chk #(
  parameter int BLK_W = 58,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             vcQuery,
  input logic             vcHit,
  input logic             memReqValid,
  input logic [BLK_W-1:0] memReqAddr,
  input logic             memFillDone,
  input logic             replTouch,
  input logic             replIsInstall,
  input logic             evictValid,
  input logic [CNT_W-1:0] cntAccess,
  input logic [CNT_W-1:0] cntMiss
);

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_rsp_not_ready_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  p_touch_then_rsp_r3: assert property (@(posedge clk) disable iff (!rstN)
    replTouch |=> rspValid);

  p_vc_hit_no_mem_r4: assert property (@(posedge clk) disable iff (!rstN)
    (vcQuery && vcHit) |=> !memReqValid);

  p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memFillDone) |=> (memReqValid && $stable(memReqAddr)));

  p_evict_on_install_r9: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |-> (replTouch && replIsInstall));

  p_touch_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    replTouch |=> !replTouch);

  p_access_mono_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cntAccess >= $past(cntAccess)));

  p_miss_le_access_r11: assert property (@(posedge clk) disable iff (!rstN)
    cntMiss <= cntAccess);

endmodule

bind l1d_tag_ctrl l1d_tag_chk #(.BLK_W(ADDR_W - B), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .vcQuery(vcQuery), .vcHit(vcHit),
  .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memFillDone(memFillDone),
  .replTouch(replTouch), .replIsInstall(replIsInstall), .evictValid(evictValid),
  .cntAccess(cntAccess), .cntMiss(cntMiss)
);

// File: tb/test_l1d_tag_ctrl.sv
module test_l1d_tag_ctrl;

  localparam int AW    = 64;
  localparam int C     = 10;
  localparam int B     = 6;
  localparam int S     = 1;
  localparam int CW    = 6;
  localparam int WAYS  = 1 << S;
  localparam int IDX_W = C - S - B;
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = AW - (C - S);
  localparam int BLK_W = AW - B;
  localparam int CMAX  = (1 << CW) - 1;
  localparam int VB_N  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqStore = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic vcHit = 1'b0, vcDirty = 1'b0, memFillDone = 1'b0;
  logic [S-1:0] replWay = '0;
  logic reqReady, rspValid, rspHit, rspFromVictim, vcQuery, memReqValid;
  logic replTouch, replIsInstall, evictValid, evictDirty;
  logic [BLK_W-1:0] vcQueryAddr, memReqAddr, evictAddr;
  logic [IDX_W-1:0] replSet;
  logic [S-1:0] replTouchWay;
  logic [CW-1:0] cntAccess, cntLoad, cntStore, cntMiss, cntMissLoad, cntMissStore, cntEvict, cntDirtyEvict;

  l1d_tag_ctrl #(.ADDR_W(AW), .C(C), .B(B), .S(S), .CNT_W(CW)) i_l1d_tag_ctrl (
    .clk, .rstN, .reqValid, .reqReady, .reqAddr, .reqStore,
    .rspValid, .rspHit, .rspFromVictim, .vcQuery, .vcQueryAddr, .vcHit, .vcDirty,
    .memReqValid, .memReqAddr, .memFillDone, .replWay, .replTouch, .replIsInstall,
    .replSet, .replTouchWay, .evictValid, .evictAddr, .evictDirty,
    .cntAccess, .cntLoad, .cntStore, .cntMiss, .cntMissLoad, .cntMissStore,
    .cntEvict, .cntDirtyEvict
  );

  always #5 clk = ~clk;

  // Reference model
  logic [TAG_W-1:0] mTag [SETS][WAYS];
  bit               mValid [SETS][WAYS];
  bit               mDirty [SETS][WAYS];
  logic [BLK_W-1:0] vbAddr [VB_N];
  bit               vbV [VB_N];
  bit               vbD [VB_N];
  int               vbPtr = 0;
  int               eCnt [8];
  int               nChk = 0, nFail = 0;
  bit               lastHit;

  task automatic chkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bump(input int i);
    if (eCnt[i] < CMAX) eCnt[i]++;
  endtask

  function automatic logic [AW-1:0] mkAddr(input logic [TAG_W-1:0] t, input int idx, input int off);
    return {t, IDX_W'(idx), B'(off)};
  endfunction

  task automatic checkInstall(input int idx, input logic [TAG_W-1:0] tag, input bit st,
                              input bit fromVic, input int vj, input int rw);
    int fw = -1;
    bit newDirty;
    for (int w = 0; w < WAYS; w++) if (!mValid[idx][w] && fw < 0) fw = w;
    if (fw < 0) fw = rw;
    chkEq("R10 replTouch", replTouch, 1);
    chkEq("R10 replIsInstall", replIsInstall, 1);
    chkEq("R10 replSet", replSet, idx);
    chkEq("R8 install way", replTouchWay, fw);
    chkEq("R9 evictValid", evictValid, mValid[idx][fw]);
    if (mValid[idx][fw]) begin
      chkEq("R2/R9 evictAddr", evictAddr, {mTag[idx][fw], IDX_W'(idx)});
      chkEq("R5/R7/R9 evictDirty", evictDirty, mDirty[idx][fw]);
    end
    newDirty = st | (fromVic & vbD[vj]);
    if (fromVic) vbV[vj] = 0;
    bump(3);
    bump(st ? 5 : 4);
    if (mValid[idx][fw]) begin
      bump(6);
      if (mDirty[idx][fw]) bump(7);
      vbAddr[vbPtr] = {mTag[idx][fw], IDX_W'(idx)};
      vbV[vbPtr]    = 1;
      vbD[vbPtr]    = mDirty[idx][fw];
      vbPtr         = (vbPtr + 1) % VB_N;
    end
    mTag[idx][fw]   = tag;
    mValid[idx][fw] = 1;
    mDirty[idx][fw] = newDirty;
  endtask

  task automatic checkCounters();
    chkEq("R11 cntAccess", cntAccess, eCnt[0]);
    chkEq("R11 cntLoad", cntLoad, eCnt[1]);
    chkEq("R11 cntStore", cntStore, eCnt[2]);
    chkEq("R11 cntMiss", cntMiss, eCnt[3]);
    chkEq("R11 cntMissLoad", cntMissLoad, eCnt[4]);
    chkEq("R11 cntMissStore", cntMissStore, eCnt[5]);
    chkEq("R11 cntEvict", cntEvict, eCnt[6]);
    chkEq("R11 cntDirtyEvict", cntDirtyEvict, eCnt[7]);
  endtask

  // Called at a falling edge with the controller idle.
  task automatic access(input logic [AW-1:0] a, input bit st, input int lat);
    int idx = int'(a[C-S-1:B]);
    logic [TAG_W-1:0] tag = a[AW-1:C-S];
    logic [BLK_W-1:0] blk = a[AW-1:B];
    int hw = -1, vj = 0, rw;
    bit vh = 0;
    for (int w = 0; w < WAYS; w++) if (mValid[idx][w] && mTag[idx][w] == tag) hw = w;
    for (int j = 0; j < VB_N; j++) if (vbV[j] && vbAddr[j] == blk) begin vh = 1; vj = j; end
    rw       = int'($urandom % WAYS);
    replWay  = S'(rw);
    vcHit    = (hw < 0) && vh;
    vcDirty  = vh ? vbD[vj] : 1'($urandom);
    reqAddr  = a;
    reqStore = st;
    reqValid = 1'b1;
    chkEq("R12 reqReady idle", reqReady, 1);
    bump(0);
    bump(st ? 2 : 1);
    @(negedge clk);
    reqValid = 1'b0;
    // lookup cycle
    if (hw >= 0) begin
      chkEq("R4 no query on hit", vcQuery, 0);
      chkEq("R10 replTouch hit", replTouch, 1);
      chkEq("R10 replIsInstall hit", replIsInstall, 0);
      chkEq("R10 hit way", replTouchWay, hw);
      chkEq("R9 no evict on hit", evictValid, 0);
      if (st) mDirty[idx][hw] = 1;
      @(negedge clk);
    end else begin
      chkEq("R4 vcQuery", vcQuery, 1);
      chkEq("R4 vcQueryAddr", vcQueryAddr, blk);
      if (vh) begin
        checkInstall(idx, tag, st, 1, vj, rw);
        @(negedge clk);
        chkEq("R4 no mem request", memReqValid, 0);
      end else begin
        chkEq("R6 no touch before fill", replTouch, 0);
        @(negedge clk);
        for (int k = 0; k < lat; k++) begin
          chkEq("R6 memReqValid held", memReqValid, 1);
          chkEq("R6 memReqAddr", memReqAddr, blk);
          chkEq("R12 busy in fill", reqReady, 0);
          @(negedge clk);
        end
        chkEq("R6 memReqValid", memReqValid, 1);
        memFillDone = 1'b1;
        #1;
        checkInstall(idx, tag, st, 0, 0, rw);
        @(negedge clk);
        memFillDone = 1'b0;
      end
    end
    // response cycle
    vcHit = 1'b0;
    lastHit = rspHit;
    chkEq("R3 rspValid", rspValid, 1);
    chkEq("R3 rspHit", rspHit, hw >= 0);
    chkEq("R4 rspFromVictim", rspFromVictim, (hw < 0) && vh);
    chkEq("R12 busy in response", reqReady, 0);
    @(negedge clk);
    chkEq("R3 rspValid single", rspValid, 0);
    checkCounters();
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [TAG_W-1:0] tags [6];
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mValid[s][w] = 0; mDirty[s][w] = 0; mTag[s][w] = '0; end
    for (int j = 0; j < VB_N; j++) begin vbV[j] = 0; vbD[j] = 0; vbAddr[j] = '0; end
    for (int i = 0; i < 8; i++) eCnt[i] = 0;
    void'($urandom(32'd1234));
    tags[0] = 0; tags[1] = 1; tags[2] = 2; tags[3] = 3; tags[4] = 55'h1234; tags[5] = '1;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 reqReady after reset", reqReady, 1);
    chkEq("R1 rspValid after reset", rspValid, 0);
    chkEq("R1 memReqValid after reset", memReqValid, 0);
    checkCounters();

    // Directed corner cases
    access(mkAddr(1, 0, 4), 0, 3);
    chkEq("R1 first access misses", lastHit, 0);
    access(mkAddr(1, 0, 37), 1, 0);               // other offset, store hit
    chkEq("R2 same line other offset hits", lastHit, 1);
    access(mkAddr(2, 0, 0), 0, 59);               // 60-cycle fill into free way
    access(mkAddr(3, 0, 0), 0, 1);                // full set: evict, maybe dirty
    access(mkAddr(1, 0, 8), 0, 0);                // may return from victim buffer dirty
    access(mkAddr('1, SETS - 1, (1 << B) - 1), 1, 2);
    access(mkAddr('1, SETS - 1, 0), 0, 0);

    // Constrained random traffic, biased toward conflicts in two sets
    for (int n = 0; n < 400; n++) begin
      int idx = ($urandom % 3 == 0) ? int'($urandom % SETS) : int'($urandom % 2);
      access(mkAddr(tags[$urandom % 6], idx, int'($urandom % (1 << B))),
             1'($urandom), int'($urandom % 5));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule